// File: doc/BRIEF.md
# Addition-Chain Inverter for GF(2^163)

This block returns the multiplicative inverse of a nonzero element of the binary field GF(2^163). The field is the polynomial basis modulo the pentanomial x^163 + x^7 + x^6 + x^3 + 1. In this basis, bit i of a 163-bit word is the coefficient of x^i. A caller presents the operand and pulses `start`. Some 1.6 thousand cycles later, `done` pulses for one cycle and the inverse appears on `inv`. The inverse stays there until the next inversion completes.

Internally the block follows a fixed addition chain for 162 = m-1: 1, 2, 4, 8, 16, 32, 64, 80, 160, 162. Write b_u for a^(2^u - 1).

- Each chain step takes an earlier value b_u, squares it u' times, and multiplies the result by b_u'. This produces b_(u+u').
- A combinational XOR network performs one squaring per clock.
- A bit-serial multiplier performs each of the nine products.
- The inverse is the square of b_162.

The whole inversion therefore costs exactly 162 squarings and 9 multiplications.

Top module: `gf_inv_chain`

## Requirements
- R1: While reset is held and after it is released, `done` is 0 and `inv` is all zeros until the first inversion completes.
- R2: For any nonzero 163-bit operand, the result multiplied by the operand equals 1. The product is taken modulo x^163 + x^7 + x^6 + x^3 + 1, with bit i of each word as the coefficient of x^i.
- R3: The operand 1 (only bit 0 set) yields the result 1.
- R4: The operand x (only bit 1 set) yields x^162 + x^6 + x^5 + x^2, which has bits 162, 6, 5 and 2 set.
- R5: `done` is high for exactly one cycle per inversion. `inv` changes only in a cycle where `done` is high, and holds its value afterwards.
- R6: A `start` pulse that arrives while an inversion is in progress is ignored. Only one `done` pulse follows, and the result is the inverse of the operand that was accepted.
- R7: The cycles from an accepted `start` to `done` are the same for every operand.
- R8: Every inversion performs exactly 162 field squarings and 9 field multiplications. Each multiplication takes at least 163 cycles, so the latency is at least 9*163 + 162 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an inversion of `a_in`; ignored while busy |
| a_in | input | 163 | Nonzero field element to invert |
| done | output | 1 | One-cycle pulse when `inv` has been updated |
| inv | output | 163 | Inverse of the last accepted operand |

## Verification
A single error in a stored chain value, a squaring count or a multiplier bit corrupts the whole exponent. The product of operand and result is then a random-looking field element rather than 1. That shows up at the first `done` after the fault, roughly 1650 cycles after `start`. A miscounted squaring loop or a restarted run also moves the `done` pulse away from the constant latency seen on other operands, or adds a second pulse. Both are observable within the same run.

// File: rtl/gf_inv_pkg.sv
// Package for the GF(2^163) addition-chain inverter.
// Holds the field size, the reduction taps, the chain table and the state type.
// Assumes the chain below is a valid addition chain for FIELD_M-1.
package gf_inv_pkg;

    localparam int FIELD_M   = 163;
    localparam int CHAIN_LEN = 10;
    localparam int IDX_W     = $clog2(CHAIN_LEN);
    localparam int CNT_W     = $clog2(FIELD_M) + 1;

    // Low-order part of the field polynomial: x^7 + x^6 + x^3 + 1
    localparam logic [FIELD_M-1:0] POLY_LOW =
        (FIELD_M'(1) << 7) | (FIELD_M'(1) << 6) | (FIELD_M'(1) << 3) | FIELD_M'(1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_SQR, ST_MUL, ST_WAIT, ST_FIN
    } inv_state_t;

    // Chain value at index idx (exponent length of the stored element)
    function automatic logic [CNT_W-1:0] chain_len_at(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd0:    return CNT_W'(1);
            4'd1:    return CNT_W'(2);
            4'd2:    return CNT_W'(4);
            4'd3:    return CNT_W'(8);
            4'd4:    return CNT_W'(16);
            4'd5:    return CNT_W'(32);
            4'd6:    return CNT_W'(64);
            4'd7:    return CNT_W'(80);
            4'd8:    return CNT_W'(160);
            default: return CNT_W'(162);
        endcase
    endfunction

    // Index of the element that gets squared at step idx
    function automatic logic [IDX_W-1:0] chain_sq_src(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd1:    return IDX_W'(0);
            4'd2:    return IDX_W'(1);
            4'd3:    return IDX_W'(2);
            4'd4:    return IDX_W'(3);
            4'd5:    return IDX_W'(4);
            4'd6:    return IDX_W'(5);
            4'd7:    return IDX_W'(6);
            4'd8:    return IDX_W'(7);
            default: return IDX_W'(8);
        endcase
    endfunction

    // Index of the element multiplied in at step idx (also sets squaring count)
    function automatic logic [IDX_W-1:0] chain_mul_src(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd1:    return IDX_W'(0);
            4'd2:    return IDX_W'(1);
            4'd3:    return IDX_W'(2);
            4'd4:    return IDX_W'(3);
            4'd5:    return IDX_W'(4);
            4'd6:    return IDX_W'(5);
            4'd7:    return IDX_W'(4);
            4'd8:    return IDX_W'(7);
            default: return IDX_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/gf_sqr_net.sv
// Combinational field squaring: spreads the input into even bit positions,
// then folds every bit at or above W back down with the fixed low taps.
// Assumes the top tap of POLY is well below W so one fold pass suffices.
module gf_sqr_net #(
    parameter int W = 163,
    parameter logic [W-1:0] POLY = '0
) (
    input  logic [W-1:0] x_in,
    output logic [W-1:0] x_sq
);
    localparam int WIDE = 2*W - 1;

    logic [WIDE-1:0] spread;

    // Interleave zeros to form the unreduced square, then reduce from the top
    always_comb begin
        spread = '0;
        for (int i = 0; i < W; i++) begin
            spread[2*i] = x_in[i];
        end
        for (int i = WIDE-1; i >= W; i--) begin
            if (spread[i]) begin
                spread[i-W +: W] = spread[i-W +: W] ^ POLY;
            end
        end
        x_sq = spread[W-1:0];
    end
endmodule

// File: rtl/gf_mul_serial.sv
// Bit-serial field multiplier, most significant bit of op_b first.
// Takes W cycles after go; done pulses one cycle with prod valid.
// Assumes go is not raised while a product is in progress.
module gf_mul_serial #(
    parameter int W = 163,
    parameter logic [W-1:0] POLY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         done,
    output logic [W-1:0] prod
);
    localparam int CW = $clog2(W) + 1;

    logic [W-1:0]  a_q;
    logic [W-1:0]  b_q;
    logic [W-1:0]  acc;
    logic [CW-1:0] left;
    logic          run;
    logic [W-1:0]  acc_next;

    // One Horner step: acc*x mod P, plus op_a when the current b bit is set
    always_comb begin
        acc_next = {acc[W-2:0], 1'b0} ^ (acc[W-1] ? POLY : '0);
        if (b_q[W-1]) begin
            acc_next = acc_next ^ a_q;
        end
    end

    // Sequencing of the W accumulate steps and the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            acc  <= '0;
            left <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !run) begin
                a_q  <= op_a;
                b_q  <= op_b;
                acc  <= '0;
                left <= CW'(W);
                run  <= 1'b1;
            end else if (run) begin
                acc  <= acc_next;
                b_q  <= {b_q[W-2:0], 1'b0};
                left <= left - CW'(1);
                if (left == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign prod = acc;
endmodule

// File: rtl/gf_beta_rf.sv
// Small register file holding the chain values a^(2^u - 1).
// One write port, two asynchronous read ports; contents need no reset
// because every entry is written before it is read in a run.
module gf_beta_rf #(
    parameter int W     = 163,
    parameter int DEPTH = 10,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr0,
    input  logic [AW-1:0] raddr1,
    output logic [W-1:0]  rdata0,
    output logic [W-1:0]  rdata1
);
    logic [W-1:0] mem [DEPTH];

    // Store a newly produced chain value
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata0 = mem[raddr0];
    assign rdata1 = mem[raddr1];
endmodule

// File: rtl/gf_inv_chain.sv
// GF(2^163) inverter following a fixed addition chain for m-1.
// Each chain step loads a stored value, squares it once per clock as many
// times as the chain says, then multiplies by a second stored value.
// A final squaring turns a^(2^(m-1)-1) into a^-1. Assumes a_in is nonzero.
module gf_inv_chain
    import gf_inv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FIELD_M-1:0] a_in,
    output logic               done,
    output logic [FIELD_M-1:0] inv
);
    localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(CHAIN_LEN - 1);

    inv_state_t         state;
    logic [IDX_W-1:0]   step;
    logic [CNT_W-1:0]   sq_left;
    logic [FIELD_M-1:0] work;
    logic [FIELD_M-1:0] work_sq;
    logic [FIELD_M-1:0] rd_sq;
    logic [FIELD_M-1:0] rd_mul;
    logic [FIELD_M-1:0] mul_res;
    logic               mul_done;
    logic               mul_go;
    logic               sq_tick;
    logic               busy;
    logic               rf_we;
    logic [IDX_W-1:0]   rf_waddr;
    logic [FIELD_M-1:0] rf_wdata;
    logic               done_q;
    logic [FIELD_M-1:0] inv_q;

    assign busy    = (state != ST_IDLE);
    assign mul_go  = (state == ST_MUL);
    assign sq_tick = (state == ST_SQR) || (state == ST_FIN);

    // Register-file write: operand on accept, each product on completion
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = step;
        rf_wdata = mul_res;
        if (state == ST_IDLE && start) begin
            rf_we    = 1'b1;
            rf_waddr = '0;
            rf_wdata = a_in;
        end else if (state == ST_WAIT && mul_done) begin
            rf_we = 1'b1;
        end
    end

    gf_beta_rf #(.W(FIELD_M), .DEPTH(CHAIN_LEN)) u_rf (
        .clk    (clk),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .raddr0 (chain_sq_src(step)),
        .raddr1 (chain_mul_src(step)),
        .rdata0 (rd_sq),
        .rdata1 (rd_mul)
    );

    gf_sqr_net #(.W(FIELD_M), .POLY(POLY_LOW)) u_sqr (
        .x_in (work),
        .x_sq (work_sq)
    );

    gf_mul_serial #(.W(FIELD_M), .POLY(POLY_LOW)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mul_go),
        .op_a  (work),
        .op_b  (rd_mul),
        .done  (mul_done),
        .prod  (mul_res)
    );

    // Chain controller: load, square loop, multiply, advance, final square
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            step    <= '0;
            sq_left <= '0;
            work    <= '0;
            done_q  <= 1'b0;
            inv_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        step  <= IDX_W'(1);
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    work    <= rd_sq;
                    sq_left <= chain_len_at(chain_mul_src(step));
                    state   <= ST_SQR;
                end
                ST_SQR: begin
                    work    <= work_sq;
                    sq_left <= sq_left - CNT_W'(1);
                    if (sq_left == CNT_W'(1)) begin
                        state <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mul_done) begin
                        work <= mul_res;
                        if (step == LAST_STEP) begin
                            state <= ST_FIN;
                        end else begin
                            step  <= step + IDX_W'(1);
                            state <= ST_LOAD;
                        end
                    end
                end
                ST_FIN: begin
                    inv_q  <= work_sq;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done = done_q;
    assign inv  = inv_q;
endmodule

// File: rtl/gf_inv_chain_chk.sv
// Checker for gf_inv_chain: counts squarings and products per run and
// checks the done/result handshake. Attached to every instance by bind.
module gf_inv_chain_chk
    import gf_inv_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [FIELD_M-1:0] inv,
    input logic               sq_tick,
    input logic               mul_go
);
    logic [CNT_W:0] sq_total;
    logic [IDX_W:0] mul_total;

    // Per-run tallies, cleared when a new operand is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_total  <= '0;
            mul_total <= '0;
        end else if (start && !busy) begin
            sq_total  <= '0;
            mul_total <= '0;
        end else begin
            sq_total  <= sq_total + (CNT_W+1)'(sq_tick);
            mul_total <= mul_total + (IDX_W+1)'(mul_go);
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_INV_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(inv) |-> done); // R5

    AST_SQUARING_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sq_total == (CNT_W+1)'(FIELD_M - 1))); // R8

    AST_PRODUCT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mul_total == (IDX_W+1)'(CHAIN_LEN - 1))); // R8

    AST_MUL_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |=> !mul_go); // R8

    AST_DONE_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R6
endmodule

bind gf_inv_chain gf_inv_chain_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .inv     (inv),
    .sq_tick (sq_tick),
    .mul_go  (mul_go)
);

// File: tb/test_gf_inv_chain.sv
// Bench for gf_inv_chain: directed and seeded random operands, each result
// checked by an independent LSB-first field multiplication.
module test_gf_inv_chain;
    localparam int M = 163;
    localparam logic [M-1:0] P_LOW = (M'(1) << 7) | (M'(1) << 6) | (M'(1) << 3) | M'(1);
    localparam int MIN_LAT = 9*M + (M - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] a_in = '0;
    logic         done;
    logic [M-1:0] inv;

    int errors = 0;
    int checks = 0;
    int ref_lat = -1;
    int cycles = 0;

    always #2.5 clk = ~clk;

    gf_inv_chain i_gf_inv_chain (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .done(done), .inv(inv)
    );

    // Field product mod x^163+x^7+x^6+x^3+1, operand b scanned from bit 0
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r = '0;
        logic [M-1:0] s = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) r = r ^ s;
            s = {s[M-2:0], 1'b0} ^ (s[M-1] ? P_LOW : '0);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Run one inversion; optionally pulse a second start mid-run
    task automatic run_inv(input logic [M-1:0] a, input bit disturb, output logic [M-1:0] res);
        int lat = 0;
        @(negedge clk);
        start = 1'b1;
        a_in  = a;
        @(negedge clk);
        start = 1'b0;
        a_in  = ~a;
        lat = 1;
        while (!done && lat < 5000) begin
            if (disturb && lat == 300) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        res = inv;
        // R7: identical latency for every operand
        if (ref_lat < 0) ref_lat = lat;
        check("R7", M'(lat), M'(ref_lat));
        // R8: nine serial products plus the squarings bound the latency from below
        check("R8", M'(lat >= MIN_LAT), M'(1));
        // R5: done falls after one cycle, result holds
        @(negedge clk);
        check("R5", M'(done), M'(0));
        check("R5", inv, res);
        if (disturb) begin
            // R6: no second completion from the ignored start
            repeat (2000) begin
                @(negedge clk);
                if (done) break;
            end
            check("R6", M'(done), M'(0));
            check("R6", inv, res);
        end
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<190000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [M-1:0] res;
        logic [M-1:0] a;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", M'(done), M'(0));
        check("R1", inv, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", M'(done), M'(0));
        check("R1", inv, '0);

        // R3: operand 1
        run_inv(M'(1), 1'b0, res);
        check("R3", res, M'(1));
        // R4: operand x
        run_inv(M'(2), 1'b0, res);
        check("R4", res, (M'(1) << 162) | (M'(1) << 6) | (M'(1) << 5) | (M'(1) << 2));
        check("R2", ref_mul(M'(2), res), M'(1));
        // R2: top coefficient alone, and all ones
        run_inv(M'(1) << (M-1), 1'b0, res);
        check("R2", ref_mul(M'(1) << (M-1), res), M'(1));
        run_inv('1, 1'b0, res);
        check("R2", ref_mul('1, res), M'(1));
        // R6: start during a run is ignored
        a = M'(32'h1234_5678) << 90 | M'(32'h9abc_def1);
        run_inv(a, 1'b1, res);
        check("R6", ref_mul(a, res), M'(1));
        // R2: seeded random nonzero operands
        for (int n = 0; n < 12; n++) begin
            a = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            if (a == '0) a = M'(3);
            run_inv(a, 1'b0, res);
            check("R2", ref_mul(a, res), M'(1));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule